// File: doc/BRIEF.md
# Ratio-Coded Single-Line Command Receiver

This block takes commands that a controller sends over one shared, open-drain wire. A bit has no fixed sample point. Instead, the receiver compares how long the wire stays low with how long it stays high within that bit. A bit runs from one falling edge to the next. Because only the ratio of the two phases matters, the controller may send at any rate over a wide range, and the rate may vary from bit to bit.

A free-running counter stamps every edge. At each falling edge the bit that just ended is classified and shifted in, first bit first. The end of a command is marked by the wire staying low after the final falling edge. At that point the frame is checked for a fixed address, an exact length of 24 bits and the absence of unreadable bits. A frame that passes updates the 9-bit brightness code and raises a one-cycle strobe. If the frame also asks for it, the block pulls the wire low for a bounded window after a fixed delay, so the controller can read back that the command arrived.

The input line is assumed to be already synchronized to `clk`. The end-of-stream timeout is a run-time input, given in clock cycles.

Top module: `ratio_cmd_rx`

## Requirements
- R1: While reset is asserted, and after it is released, `code_o` is 511 (all ones), `code_valid_o` is 0 and `ack_pull_o` is 0, until a command is accepted.
- R2: A bit spans from one falling edge of `line_i` to the next. Let L be the number of low cycles and H the number of high cycles in that span. The bit is 0 when L >= 2*H and 1 when H >= 2*L. The result depends only on this ratio, not on the absolute lengths.
- R3: Bits are collected into a word W with the first bit received stored as W[0]. A command is accepted when it holds exactly 24 bits, W[23:16] equals 8'h8F and no bit was unreadable. On acceptance, `code_o` takes W[8:0] and `code_valid_o` is high for exactly one cycle.
- R4: The end of a command is detected when `line_i` stays low after the final falling edge. If that falling edge is first sampled at clock edge k, the new code and the strobe appear after edge k + `eos_cycles_i`. Every low phase inside a bit must be shorter than `eos_cycles_i`.
- R5: A frame whose W[23:16] differs from 8'h8F leaves `code_o` unchanged and produces no strobe and no acknowledge.
- R6: A frame with fewer or more than 24 bits leaves `code_o` unchanged and produces no strobe and no acknowledge.
- R7: A frame that contains a bit with neither L >= 2*H nor H >= 2*L is discarded without a strobe or an acknowledge.
- R8: If `line_i` stays high for `eos_cycles_i` cycles during a frame, the partial frame is dropped. The next falling edge then starts a new frame, which is decoded normally.
- R9: An accepted frame with W[10] = 1 drives `ack_pull_o` high for ACK_LEN consecutive cycles, starting ACK_DLY cycles after the strobe cycle. With W[10] = 0 there is no acknowledge. `ack_pull_o` is never high outside such a window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also used as shutdown |
| line_i | input | 1 | Synchronized level of the command wire |
| eos_cycles_i | input | TS_W | End-of-stream and idle-abort timeout, in cycles |
| code_o | output | CODE_W | Stored brightness code |
| code_valid_o | output | 1 | One-cycle strobe when a command is accepted |
| ack_pull_o | output | 1 | Request to pull the wire low for the acknowledge |

## Verification
The hardest case to reach from the ports is a frame that is abandoned halfway through by a long high phase and followed at once by a clean command. Only the second frame may take effect, and no stale bit or count from the first may leak into it. The stimulus sends ten bits, holds the wire high past the timeout, then sends a full command without any separate start gap. Other frames are built with one deliberately ambiguous bit, with one bit too few or too many, and with a wrong address. Clean commands are sent at two bit rates to show that only the ratio matters.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_BUSY = 1'b1
  } rx_state_e;
endpackage

// File: rtl/rcr_edge_stamp.sv
module rcr_edge_stamp #(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            line_i,
  output logic            fall_o,
  output logic            rise_o,
  output logic [TS_W-1:0] low_len_o,
  output logic [TS_W-1:0] since_rise_o,
  output logic [TS_W-1:0] since_fall_o
);
  logic            line_q;
  logic [TS_W-1:0] now_q, t_fall_q, t_rise_q;
  logic [TS_W-1:0] t_fall_d, t_rise_d;

  assign fall_o = line_q & ~line_i;
  assign rise_o = ~line_q & line_i;

  always_comb begin
    t_fall_d = t_fall_q;
    t_rise_d = t_rise_q;
    if (fall_o) t_fall_d = now_q;
    if (rise_o) t_rise_d = now_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q   <= 1'b1;
      now_q    <= '0;
      t_fall_q <= '0;
      t_rise_q <= '0;
    end else begin
      line_q   <= line_i;
      now_q    <= now_q + 1'b1;
      t_fall_q <= t_fall_d;
      t_rise_q <= t_rise_d;
    end
  end

  assign low_len_o    = t_rise_q - t_fall_q;
  assign since_rise_o = now_q - t_rise_q;
  assign since_fall_o = now_q - t_fall_q;
endmodule

// File: rtl/rcr_bit_class.sv
module rcr_bit_class #(
  parameter int TS_W = 16
) (
  input  logic [TS_W-1:0] low_i,
  input  logic [TS_W-1:0] high_i,
  output logic            bit_o,
  output logic            bad_o
);
  logic [TS_W:0] low_w, high_w, low_x2, high_x2;
  logic          is_zero, is_one;

  assign low_w   = {1'b0, low_i};
  assign high_w  = {1'b0, high_i};
  assign low_x2  = {low_i, 1'b0};
  assign high_x2 = {high_i, 1'b0};

  assign is_zero = (low_w >= high_x2);
  assign is_one  = (high_w >= low_x2);

  assign bit_o = is_one & ~is_zero;
  assign bad_o = ~(is_zero | is_one);
endmodule

// File: rtl/rcr_frame.sv
module rcr_frame
  import rcr_pkg::*;
#(
  parameter int                TS_W     = 16,
  parameter int                FRAME_W  = 24,
  parameter int                CODE_W   = 9,
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 8'h8F,
  parameter int                ACK_POS  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_i,
  input  logic              fall_i,
  input  logic              rise_i,
  input  logic              bit_i,
  input  logic              bad_i,
  input  logic [TS_W-1:0]   since_fall_i,
  input  logic [TS_W-1:0]   since_rise_i,
  input  logic [TS_W-1:0]   eos_cycles_i,
  input  logic              ack_busy_i,
  output logic [CODE_W-1:0] code_o,
  output logic              code_valid_o,
  output logic              ack_start_o
);
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam int CNT_MAX = FRAME_W + 1;

  rx_state_e          state_q, state_d;
  logic [FRAME_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               err_q, err_d;
  logic [CODE_W-1:0]  code_q, code_d;
  logic               valid_q, valid_d;
  logic               eos_hit, hi_abort, addr_ok, len_ok, accept;

  assign addr_ok  = (sr_q[FRAME_W-1 -: ADDR_W] == DEV_ADDR);
  assign len_ok   = (cnt_q == CNT_W'(FRAME_W));
  assign accept   = addr_ok & len_ok & ~err_q;
  assign eos_hit  = (state_q == RX_BUSY) && !line_i && !fall_i &&
                    (since_fall_i >= eos_cycles_i);
  assign hi_abort = (state_q == RX_BUSY) && line_i && !rise_i &&
                    (since_rise_i >= eos_cycles_i);

  always_comb begin
    state_d     = state_q;
    sr_d        = sr_q;
    cnt_d       = cnt_q;
    err_d       = err_q;
    code_d      = code_q;
    valid_d     = 1'b0;
    ack_start_o = 1'b0;
    case (state_q)
      RX_IDLE: begin
        if (fall_i && !ack_busy_i) begin
          state_d = RX_BUSY;
          cnt_d   = '0;
          err_d   = 1'b0;
        end
      end
      RX_BUSY: begin
        if (fall_i) begin
          sr_d  = {bit_i, sr_q[FRAME_W-1:1]};
          err_d = err_q | bad_i;
          if (cnt_q != CNT_W'(CNT_MAX)) cnt_d = cnt_q + 1'b1;
        end else if (eos_hit) begin
          state_d = RX_IDLE;
          if (accept) begin
            code_d      = sr_q[CODE_W-1:0];
            valid_d     = 1'b1;
            ack_start_o = sr_q[ACK_POS];
          end
        end else if (hi_abort) begin
          state_d = RX_IDLE;
        end
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      sr_q    <= '0;
      cnt_q   <= '0;
      err_q   <= 1'b0;
      code_q  <= '1;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      sr_q    <= sr_d;
      cnt_q   <= cnt_d;
      err_q   <= err_d;
      code_q  <= code_d;
      valid_q <= valid_d;
    end
  end

  assign code_o       = code_q;
  assign code_valid_o = valid_q;
endmodule

// File: rtl/rcr_ack.sv
module rcr_ack #(
  parameter int ACK_DLY = 8,
  parameter int ACK_LEN = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic pull_o,
  output logic busy_o
);
  localparam int TOT = ACK_DLY + ACK_LEN;
  localparam int CW  = $clog2(TOT + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start_i)            cnt_d = CW'(TOT);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);
  assign pull_o = (cnt_q != '0) && (cnt_q <= CW'(ACK_LEN));
endmodule

// File: rtl/ratio_cmd_rx.sv
module ratio_cmd_rx #(
  parameter int                TS_W     = 16,
  parameter int                FRAME_W  = 24,
  parameter int                CODE_W   = 9,
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 8'h8F,
  parameter int                ACK_POS  = 10,
  parameter int                ACK_DLY  = 8,
  parameter int                ACK_LEN  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_i,
  input  logic [TS_W-1:0]   eos_cycles_i,
  output logic [CODE_W-1:0] code_o,
  output logic              code_valid_o,
  output logic              ack_pull_o
);
  logic            fall, rise, bit_val, bit_bad, ack_start, ack_busy;
  logic [TS_W-1:0] low_len, since_rise, since_fall;

  rcr_edge_stamp #(.TS_W(TS_W)) u_stamp (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_i       (line_i),
    .fall_o       (fall),
    .rise_o       (rise),
    .low_len_o    (low_len),
    .since_rise_o (since_rise),
    .since_fall_o (since_fall)
  );

  rcr_bit_class #(.TS_W(TS_W)) u_class (
    .low_i  (low_len),
    .high_i (since_rise),
    .bit_o  (bit_val),
    .bad_o  (bit_bad)
  );

  rcr_frame #(
    .TS_W     (TS_W),
    .FRAME_W  (FRAME_W),
    .CODE_W   (CODE_W),
    .ADDR_W   (ADDR_W),
    .DEV_ADDR (DEV_ADDR),
    .ACK_POS  (ACK_POS)
  ) u_frame (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_i       (line_i),
    .fall_i       (fall),
    .rise_i       (rise),
    .bit_i        (bit_val),
    .bad_i        (bit_bad),
    .since_fall_i (since_fall),
    .since_rise_i (since_rise),
    .eos_cycles_i (eos_cycles_i),
    .ack_busy_i   (ack_busy),
    .code_o       (code_o),
    .code_valid_o (code_valid_o),
    .ack_start_o  (ack_start)
  );

  rcr_ack #(.ACK_DLY(ACK_DLY), .ACK_LEN(ACK_LEN)) u_ack (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (ack_start),
    .pull_o  (ack_pull_o),
    .busy_o  (ack_busy)
  );
endmodule

// File: rtl/rcr_chk.sv
module rcr_chk #(
  parameter int CODE_W  = 9,
  parameter int ACK_DLY = 8,
  parameter int ACK_LEN = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] code_o,
  input logic              code_valid_o,
  input logic              ack_pull_o
);
  localparam int SW = $clog2(ACK_DLY + ACK_LEN + 2) + 1;

  logic [SW-1:0] since_q;
  logic [SW-1:0] since_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                since_q <= '1;
    else if (code_valid_o)     since_q <= SW'(1);
    else if (since_q != '1)    since_q <= since_q + 1'b1;
  end

  assign since_v = code_valid_o ? '0 : since_q;

  assert_reset_value_R1: assert property (@(posedge clk)
    !rst_n |=> (code_o == {CODE_W{1'b1}} && !code_valid_o && !ack_pull_o));

  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid_o |=> !code_valid_o);

  assert_code_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !code_valid_o |-> (code_o == $past(code_o)));

  assert_ack_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_pull_o |-> (since_v >= SW'(ACK_DLY) && since_v < SW'(ACK_DLY + ACK_LEN)));
endmodule

bind ratio_cmd_rx rcr_chk #(
  .CODE_W  (CODE_W),
  .ACK_DLY (ACK_DLY),
  .ACK_LEN (ACK_LEN)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .code_o       (code_o),
  .code_valid_o (code_valid_o),
  .ack_pull_o   (ack_pull_o)
);

// File: tb/ratio_cmd_rx_bench.sv
`timescale 1ns/1ps
module ratio_cmd_rx_bench;
  localparam int TS_W    = 16;
  localparam int ACK_DLY = 8;
  localparam int ACK_LEN = 64;
  localparam int EOS     = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        drv = 1'b1;
  logic [8:0]  code_o;
  logic        code_valid_o;
  logic        ack_pull_o;

  int n_chk = 0;
  int n_fail = 0;
  int n_valid = 0;
  int n_ack = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ratio_cmd_rx #(.TS_W(TS_W), .ACK_DLY(ACK_DLY), .ACK_LEN(ACK_LEN)) u_ratio_cmd_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_i       (drv),
    .eos_cycles_i (TS_W'(EOS)),
    .code_o       (code_o),
    .code_valid_o (code_valid_o),
    .ack_pull_o   (ack_pull_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference model
  int          cyc, tf, tr, nb, ack_t;
  bit          prv, busy, bad;
  logic [31:0] bits;
  logic [8:0]  m_code;
  bit          m_valid;

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0; tf = 0; tr = 0; nb = 0; ack_t = 0;
      prv = 1; busy = 0; bad = 0; bits = '0;
      m_code = 9'h1FF; m_valid = 0;
    end else begin
      bit L, fall, rise, nv, st_ack, b;
      int lo, hi;
      L = drv; fall = prv && !L; rise = !prv && L;
      nv = 0; st_ack = 0;
      if (!busy) begin
        if (fall && ack_t == 0) begin busy = 1; nb = 0; bad = 0; bits = '0; end
      end else if (fall) begin
        lo = tr - tf; hi = cyc - tr;
        if (lo >= 2*hi) b = 0;
        else if (hi >= 2*lo) b = 1;
        else begin b = 0; bad = 1; end
        if (nb < 32) bits[nb] = b;
        nb++;
      end else if (!L && (cyc - tf) >= EOS) begin
        busy = 0;
        if (!bad && nb == 24 && bits[23:16] == 8'h8F) begin
          m_code = bits[8:0]; nv = 1; st_ack = bits[10];
        end
      end else if (L && !rise && (cyc - tr) >= EOS) begin
        busy = 0;
      end
      if (fall) tf = cyc;
      if (rise) tr = cyc;
      if (st_ack) ack_t = ACK_DLY + ACK_LEN;
      else if (ack_t > 0) ack_t--;
      m_valid = nv;
      prv = L;
      cyc++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit m_ack;
      m_ack = (ack_t != 0) && (ack_t <= ACK_LEN);
      chk(code_o == m_code, "R3 code per cycle", code_o, m_code);
      chk(code_valid_o == m_valid, "R4 strobe per cycle", code_valid_o, m_valid);
      chk(ack_pull_o == m_ack, "R9 ack per cycle", ack_pull_o, m_ack);
      if (code_valid_o) n_valid++;
      if (ack_pull_o) n_ack++;
    end
  end

  task automatic drive(input logic v, input int n);
    drv = v;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] mk(input logic [7:0] addr, input bit ack, input logic [8:0] code);
    return {8'h00, addr, 5'b0, ack, 1'b0, code};
  endfunction

  task automatic send_bits(input logic [31:0] w, input int nbits, input int u, input int bad_at);
    for (int i = 0; i < nbits; i++) begin
      int lo, hi;
      if (i == bad_at)  begin lo = 2*u; hi = 2*u; end
      else if (w[i])    begin lo = u;   hi = 3*u; end
      else              begin lo = 3*u; hi = u;   end
      drive(1'b0, lo);
      drive(1'b1, hi);
    end
  endtask

  task automatic send_frame(input logic [31:0] w, input int nbits, input int u, input int bad_at);
    send_bits(w, nbits, u, bad_at);
    drive(1'b0, EOS + ACK_DLY + ACK_LEN + 8);
    drive(1'b1, 30);
  endtask

  task automatic frame_expect(input logic [31:0] w, input int nbits, input int u, input int bad_at,
                              input string req, input int exp_code, input int exp_v, input int exp_a);
    int v0, a0;
    v0 = n_valid; a0 = n_ack;
    send_frame(w, nbits, u, bad_at);
    chk(code_o == 9'(exp_code), {req, " code"}, code_o, exp_code);
    chk((n_valid - v0) == exp_v, {req, " strobes"}, n_valid - v0, exp_v);
    chk((n_ack - a0) == exp_a, {req, " ack cycles"}, n_ack - a0, exp_a);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(code_o == 9'h1FF, "R1 reset code", code_o, 511);
    chk(code_valid_o == 1'b0, "R1 reset strobe", code_valid_o, 0);
    chk(ack_pull_o == 1'b0, "R1 reset ack", ack_pull_o, 0);
    rst_n = 1'b1;
    drive(1'b1, 20);
    chk(code_o == 9'h1FF, "R1 after release", code_o, 511);

    // R2 R3 fast rate, no acknowledge
    frame_expect(mk(8'h8F, 0, 9'h0A5), 24, 2, -1, "R3 fast", 9'h0A5, 1, 0);
    // R2 R9 slow rate with acknowledge
    frame_expect(mk(8'h8F, 1, 9'h153), 24, 6, -1, "R9 slow ack", 9'h153, 1, ACK_LEN);
    // R2 same code at another rate
    frame_expect(mk(8'h8F, 0, 9'h0A5), 24, 5, -1, "R2 rate", 9'h0A5, 1, 0);
    // R5 wrong address
    frame_expect(mk(8'h8E, 1, 9'h011), 24, 2, -1, "R5 addr", 9'h0A5, 0, 0);
    // R6 short and long frames
    frame_expect(mk(8'h8F, 1, 9'h0F0), 23, 2, -1, "R6 short", 9'h0A5, 0, 0);
    frame_expect(mk(8'h8F, 1, 9'h0F0), 25, 2, -1, "R6 long", 9'h0A5, 0, 0);
    // R7 ambiguous bit
    frame_expect(mk(8'h8F, 1, 9'h0F0), 24, 3, 4, "R7 ambiguous", 9'h0A5, 0, 0);
    // R8 abandoned partial frame, then a clean one
    send_bits(mk(8'h8F, 0, 9'h1C3), 10, 2, -1);
    drive(1'b1, EOS + 10);
    chk(code_o == 9'h0A5, "R8 partial dropped", code_o, 9'h0A5);
    frame_expect(mk(8'h8F, 0, 9'h001), 24, 2, -1, "R8 after abort", 9'h001, 1, 0);
    // R3 boundary codes
    frame_expect(mk(8'h8F, 0, 9'h000), 24, 3, -1, "R3 zero", 0, 1, 0);
    frame_expect(mk(8'h8F, 1, 9'h1FF), 24, 3, -1, "R3 full", 511, 1, ACK_LEN);
    frame_expect(mk(8'h8F, 0, 9'h07E), 24, 2, -1, "R3 mid", 9'h07E, 1, 0);

    // R1 shutdown returns to all ones
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(code_o == 9'h1FF, "R1 shutdown code", code_o, 511);
    rst_n = 1'b1;
    drive(1'b1, 10);
    chk(code_o == 9'h1FF, "R1 after shutdown", code_o, 511);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule